// File: doc/BRIEF.md
# Read-Address Unlock Command Detector

This block sits beside an SRAM-style memory port and watches the chip-enable-controlled read cycles on it. A memory controller or firmware can ask for a nonvolatile save or restore of the array by reading a fixed, ordered series of six addresses, without a command register or a dedicated pin. When the block recognises the full series, it raises a one-cycle request toward a downstream nonvolatile controller. The last address of the series selects which request is raised.

A cycle is counted when the active-low chip enable is seen falling. The block samples chip enable on the clock and compares the falling edge with the value it held on the previous clock. The first five reads of the series are ordinary reads. In the sixth, command-carrying cycle the block tells the data path to float its outputs. The downstream controller can hold the detector off with a busy input while it carries out a command. The memory array, the nonvolatile cells and the save timing sit outside this block.

Top module: `nv_cmd_seq_detect`

## Requirements
- R1: During and right after reset, store_req, recall_req, data_hiz and in_seq are all 0.
- R2: Six read cycles (we_n high) at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 produce store_req high for exactly one clock. The pulse is in the clock after the edge that samples the sixth falling chip enable.
- R3: The same five leading addresses followed by 0x0C63 produce a one-clock recall_req pulse with the same timing as R2.
- R4: Only addr[13:0] is compared. addr[14] has no effect on matching.
- R5: Any clock in which ce_n and we_n are both sampled low while ctl_busy is low returns the matcher to idle (in_seq 0).
- R6: A read whose address is not the next expected one returns the matcher to idle. If that address equals 0x0E38, the matcher instead holds one match (in_seq 1). This also applies to a wrong sixth address.
- R7: Only a falling edge of ce_n counts as a cycle. Keeping ce_n low while the address changes does not advance the matcher.
- R8: data_hiz rises together with a command pulse and stays high until ce_n is sampled high. It stays 0 during the five leading reads.
- R9: oe_n has no effect on recognition.
- R10: While ctl_busy is high, falling edges and writes are ignored. No request is raised and the match progress (in_seq) is kept.
- R11: After a command pulse the matcher is idle (in_seq 0).
- R12: store_req and recall_req are never high together, and neither is high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable of the memory port |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable (does not affect detection) |
| addr | input | 15 | Memory port address |
| ctl_busy | input | 1 | Downstream controller busy; detection is frozen while high |
| store_req | output | 1 | One-clock save request |
| recall_req | output | 1 | One-clock restore request |
| data_hiz | output | 1 | Data outputs must float during the command cycle |
| in_seq | output | 1 | Matcher holds at least one match |

## Verification
The bench targets the restart rule: a wrong address that happens to be the first key must leave one match, not zero. A design that always falls back to idle would miss the store that the following five reads complete. It holds chip enable low while walking the address through the series, which catches a level-sensitive matcher that runs through the whole series in a few clocks. It raises busy in the middle of a series and then finishes the series afterwards. A design that clears its progress under busy, or that acts on cycles seen while busy, issues no command or a wrong one. It also sets the ignored top address bit, aborts with a write, and checks that the float flag drops exactly when chip enable goes high.

// File: rtl/nv_cmd_seq_detect.sv
module nv_cmd_seq_detect #(
  parameter int AW = 15,
  parameter int MW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic          ctl_busy,
  output logic          store_req,
  output logic          recall_req,
  output logic          data_hiz,
  output logic          in_seq
);
  localparam int LAST_IDX = 5;
  localparam int CW = $clog2(LAST_IDX + 1);

  localparam logic [MW-1:0] KEY_STORE  = MW'(14'h0FC0);
  localparam logic [MW-1:0] KEY_RECALL = MW'(14'h0C63);

  function automatic logic [MW-1:0] key_at(input logic [CW-1:0] idx);
    case (idx)
      CW'(0):  key_at = MW'(14'h0E38);
      CW'(1):  key_at = MW'(14'h31C7);
      CW'(2):  key_at = MW'(14'h03E0);
      CW'(3):  key_at = MW'(14'h3C1F);
      CW'(4):  key_at = MW'(14'h303F);
      default: key_at = '0;
    endcase
  endfunction

  logic          ce_q;
  logic [CW-1:0] cnt;

  wire [MW-1:0] a_lo     = addr[MW-1:0];
  wire          rd_fall  = ce_q & ~ce_n & we_n & ~ctl_busy;
  wire          wr_abort = ~ce_n & ~we_n & ~ctl_busy;
  wire          at_last  = (cnt == CW'(LAST_IDX));
  wire          hit_next = ~at_last & (a_lo == key_at(cnt));
  wire          hit_head = (a_lo == key_at(CW'(0)));
  wire          is_store = at_last & (a_lo == KEY_STORE);
  wire          is_recal = at_last & (a_lo == KEY_RECALL);
  wire          is_cmd   = is_store | is_recal;

  wire unused_ok = &{1'b0, oe_n, addr[AW-1:MW]};

  assign in_seq = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q       <= 1'b1;
      cnt        <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
      data_hiz   <= 1'b0;
    end else begin
      ce_q       <= ce_n;
      store_req  <= rd_fall & is_store;
      recall_req <= rd_fall & is_recal;
      if (ce_n)                 data_hiz <= 1'b0;
      else if (rd_fall & is_cmd) data_hiz <= 1'b1;
      if (wr_abort)             cnt <= '0;
      else if (rd_fall) begin
        if (is_cmd)             cnt <= '0;
        else if (hit_next)      cnt <= cnt + CW'(1);
        else                    cnt <= hit_head ? CW'(1) : '0;
      end
    end
  end
endmodule

// File: rtl/nv_cmd_seq_detect_chk.sv
module nv_cmd_seq_detect_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        we_n,
  input logic [14:0] addr,
  input logic        ctl_busy,
  input logic        store_req,
  input logic        recall_req,
  input logic        data_hiz,
  input logic        in_seq
);
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));
  p_store_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  p_recall_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);
  p_store_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(!ce_n && we_n && !ctl_busy && addr[13:0] == 14'h0FC0));
  p_recall_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> $past(!ce_n && we_n && !ctl_busy && addr[13:0] == 14'h0C63));
  p_write_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n && !ctl_busy) |=> !in_seq);
  p_hiz_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_hiz) |-> (store_req || recall_req));
  p_hiz_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !data_hiz);
  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_busy |=> (!store_req && !recall_req));
  p_busy_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_busy |=> $stable(in_seq));
  p_idle_after_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> !in_seq);
endmodule

bind nv_cmd_seq_detect nv_cmd_seq_detect_chk u_chk (.*);

// File: tb/nv_cmd_seq_detect_tb_top.sv
module nv_cmd_seq_detect_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ctl_busy = 1'b0;
  logic [14:0] addr = '0;
  logic store_req, recall_req, data_hiz, in_seq;

  always #5 clk = ~clk;

  nv_cmd_seq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .ctl_busy(ctl_busy), .store_req(store_req),
    .recall_req(recall_req), .data_hiz(data_hiz), .in_seq(in_seq)
  );

  typedef struct {
    int    due;
    bit    st, rc, hz, sq;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int m_cnt = 0;
  logic [13:0] keys [5] = '{14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F, 14'h303F};
  localparam logic [14:0] ST_A = 15'h0FC0;
  localparam logic [14:0] RC_A = 15'h0C63;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input exp_t e);
    n_chk++;
    if (store_req !== e.st || recall_req !== e.rc || data_hiz !== e.hz || in_seq !== e.sq) begin
      n_fail++;
      $display("FAIL %s: st/rc/hz/sq actual %b%b%b%b expected %b%b%b%b at cycle %0d",
               e.tag, store_req, recall_req, data_hiz, in_seq, e.st, e.rc, e.hz, e.sq, cyc);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) compare(q.pop_front());
  end

  task automatic push(input bit st, input bit rc, input bit hz, input string tag);
    exp_t e;
    e.due = cyc + 1; e.st = st; e.rc = rc; e.hz = hz; e.sq = (m_cnt != 0); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic acc(input logic [14:0] a, input bit we, input bit oe, input string tag);
    bit st = 0, rc = 0;
    logic [13:0] lo = a[13:0];
    @(negedge clk);
    ce_n = 1'b0; addr = a; we_n = we; oe_n = oe;
    if (!ctl_busy) begin
      if (!we) m_cnt = 0;
      else if (m_cnt == 5 && lo == ST_A[13:0]) begin st = 1; m_cnt = 0; end
      else if (m_cnt == 5 && lo == RC_A[13:0]) begin rc = 1; m_cnt = 0; end
      else if (m_cnt < 5 && lo == keys[m_cnt]) m_cnt++;
      else m_cnt = (lo == keys[0]) ? 1 : 0;
    end
    push(st, rc, st | rc, tag);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    push(1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic lead(input int from, input int upto, input logic [14:0] hi, input bit oe, input string tag);
    for (int i = from; i < upto; i++) acc({1'b0, keys[i]} | hi, 1'b1, oe, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (store_req | recall_req | data_hiz | in_seq) begin
      n_fail++;
      $display("FAIL R1: outputs actual %b%b%b%b expected 0000", store_req, recall_req, data_hiz, in_seq);
    end
    rst_n = 1'b1;
    push(1'b0, 1'b0, 1'b0, "R1");

    lead(0, 5, 15'h0, 1'b1, "R8");
    acc(ST_A, 1'b1, 1'b1, "R2 R11");

    lead(0, 5, 15'h0, 1'b0, "R9");
    acc(RC_A, 1'b1, 1'b0, "R3 R12");

    lead(0, 5, 15'h4000, 1'b0, "R4");
    acc(ST_A | 15'h4000, 1'b1, 1'b0, "R4");

    lead(0, 3, 15'h0, 1'b0, "R5");
    acc({1'b0, keys[3]}, 1'b0, 1'b0, "R5");
    lead(3, 5, 15'h0, 1'b0, "R5");
    acc(ST_A, 1'b1, 1'b0, "R5");

    lead(0, 2, 15'h0, 1'b0, "R6");
    acc(15'h1234, 1'b1, 1'b0, "R6");
    lead(0, 2, 15'h0, 1'b0, "R6");
    acc({1'b0, keys[0]}, 1'b1, 1'b0, "R6");
    lead(1, 5, 15'h0, 1'b0, "R6");
    acc(ST_A, 1'b1, 1'b0, "R6");
    lead(0, 5, 15'h0, 1'b0, "R6");
    acc({1'b0, keys[0]}, 1'b1, 1'b0, "R6");
    acc(15'h0FC1, 1'b1, 1'b0, "R6");

    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b1; addr = {1'b0, keys[0]};
    m_cnt = 1;
    push(1'b0, 1'b0, 1'b0, "R7");
    for (int i = 1; i < 5; i++) begin
      @(negedge clk);
      addr = {1'b0, keys[i]};
      push(1'b0, 1'b0, 1'b0, "R7");
    end
    @(negedge clk);
    addr = ST_A;
    push(1'b0, 1'b0, 1'b0, "R7");
    @(negedge clk);
    ce_n = 1'b1;
    push(1'b0, 1'b0, 1'b0, "R7");
    acc(15'h0, 1'b1, 1'b0, "R7");

    lead(0, 2, 15'h0, 1'b0, "R10");
    ctl_busy = 1'b1;
    acc(15'h0000, 1'b1, 1'b0, "R10");
    acc({1'b0, keys[2]}, 1'b0, 1'b0, "R10");
    acc(RC_A, 1'b1, 1'b0, "R10");
    @(negedge clk);
    ctl_busy = 1'b0;
    lead(2, 5, 15'h0, 1'b0, "R10");
    acc(ST_A, 1'b1, 1'b0, "R10 R2");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: pending actual %0d expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule